// File: doc/BRIEF.md
# Spectral Peak Selector

This block sits after a per-bin amplitude/phase stage in a multi-channel spectrum pipeline. Each spectral item arrives as a streamed word carrying a channel number, a bin index, a 32-bit amplitude and a 32-bit phase. For every channel the block keeps only the bin whose amplitude is largest. The search covers the positive-frequency half of a real-input spectrum and leaves out the DC bin. All other bins are dropped.

When the final bin of the final channel has been seen, the block assembles the surviving amplitude/phase pairs of all channels into one fixed-width record. It presents that record with a one-cycle valid pulse, so a transmit stage sends a single record per block instead of every bin. With the default sizes, sixteen channels of 64 bits each give a 1024-bit record, and each channel's block holds 128 bins.

Items for different channels may be interleaved freely. Each channel keeps its own running maximum, and that maximum restarts whenever bin 0 of the channel arrives.

Top module: `peak_select_top`

## Requirements
- R1: `rec_valid` is high for exactly one cycle, in the cycle after the accepted item with channel NUM_CH-1 and bin NUM_BINS-1. It is never high at any other time.
- R2: In `rec_data`, channel c occupies bits [64c+63:64c]. Its amplitude is in bits [64c+31:64c] and its phase in bits [64c+63:64c+32], so channel 0 is the least significant slot.
- R3: Only bins 1 to NUM_BINS/2-1 (1 to 63 by default) are candidates. Bin 0 and bins NUM_BINS/2 and above are never reported, however large their amplitude.
- R4: Among the candidate bins of a channel, the one with the largest amplitude is reported, comparing amplitudes as unsigned numbers. With a tone whose peak lies at bin 14, bin 14 is reported.
- R5: When two candidate bins of a channel have equal amplitude, the lower-indexed bin is kept.
- R6: Bin 0 of a channel clears that channel's running maximum, so no value from an earlier block carries into the next record.
- R7: Items for one channel leave every other channel's result unchanged, whether channels arrive one after another or interleaved bin by bin.
- R8: Cycles with `in_valid` low have no effect, even when the data lines carry large amplitudes or the final channel/bin coordinates.
- R9: After reset `rec_valid` and `rec_data` are 0. A channel whose candidate bins all have amplitude 0 reports amplitude 0 together with the phase of its bin 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item qualifier |
| in_chan | input | 4 | Channel number of the item |
| in_bin | input | 7 | Bin index of the item |
| in_amp | input | 32 | Bin amplitude, unsigned |
| in_phase | input | 32 | Bin phase |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_data | output | 1024 | Packed per-channel peak record |

## Verification
The hardest situations to reach from the ports are those where the rules pull against each other. One is a bin outside the search window that carries a larger amplitude than the true peak. Another is a tie that must resolve to the lower bin. A third is a "last item" pattern that appears on the data lines while `in_valid` is low. The stimulus therefore builds whole blocks from amplitude patterns of its own design: a huge DC bin, a mirror image larger than the tone, flat spectra, late ties at the window edge, and hashed unsigned values with the top bit set. It also mixes channel-major and bin-interleaved ordering, and inserts idle cycles that show the final coordinates with a maximal amplitude. A reference model in the driver predicts each record and places it in a queue, and the monitor compares the record slot by slot when the strobe appears.

// File: rtl/peak_sel_pkg.sv
package peak_sel_pkg;

    localparam int AMP_W = 32;
    localparam int PH_W  = 32;

    // one record slot: phase in the upper half, amplitude in the lower half
    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [AMP_W-1:0] amp;
    } peak_t;

    localparam int SLOT_W = $bits(peak_t);

endpackage

// File: rtl/peak_tracker.sv
module peak_tracker
    import peak_sel_pkg::*;
#(
    parameter int BIN_W     = 7,
    parameter int SEARCH_HI = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [BIN_W-1:0] bin_i,
    input  logic [AMP_W-1:0] amp_i,
    input  logic [PH_W-1:0]  ph_i,
    output peak_t            peak_o
);

    typedef struct packed {
        logic [AMP_W-1:0] amp;
        logic [PH_W-1:0]  ph;
        logic [BIN_W-1:0] bin;
    } trk_s;

    localparam trk_s TRK_CLEAR = '{amp: '0, ph: '0, bin: '1};

    trk_s trk_d, trk_q;
    logic in_window;
    logic better;

    always_comb begin
        trk_d     = trk_q;
        in_window = (bin_i != '0) && (bin_i <= BIN_W'(SEARCH_HI));
        better    = (amp_i > trk_q.amp) ||
                    ((amp_i == trk_q.amp) && (bin_i < trk_q.bin));
        if (hit) begin
            if (bin_i == '0) begin
                trk_d = TRK_CLEAR;
            end else if (in_window && better) begin
                trk_d.amp = amp_i;
                trk_d.ph  = ph_i;
                trk_d.bin = bin_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= TRK_CLEAR;
        else        trk_q <= trk_d;
    end

    assign peak_o.amp = trk_q.amp;
    assign peak_o.ph  = trk_q.ph;

    AST_BIN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.bin == '1) || ((trk_q.bin != '0) && (trk_q.bin <= BIN_W'(SEARCH_HI)))); // R3
    AST_BIN0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bin_i == '0) |=> (trk_q.amp == '0 && trk_q.bin == '1)); // R6
    AST_MAX_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bin_i != '0) |=> (trk_q.amp >= $past(trk_q.amp))); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(trk_q)); // R7

endmodule

// File: rtl/record_packer.sv
module record_packer
    import peak_sel_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int REC_W = NUM_CH * SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_seen,
    input  peak_t            peaks_i [NUM_CH],
    output logic             rec_valid,
    output logic [REC_W-1:0] rec_data
);

    typedef struct packed {
        logic             vld;
        logic [REC_W-1:0] data;
    } pack_s;

    pack_s pk_d, pk_q;
    logic [REC_W-1:0] flat;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        assign flat[c*SLOT_W +: SLOT_W] = peaks_i[c];
    end

    always_comb begin
        pk_d     = pk_q;
        pk_d.vld = last_seen;
        if (last_seen) pk_d.data = flat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign rec_valid = pk_q.vld;
    assign rec_data  = pk_q.data;

    AST_STROBE_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(last_seen)); // R1
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_seen |=> $stable(rec_data)); // R2

endmodule

// File: rtl/peak_select_top.sv
module peak_select_top
    import peak_sel_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int NUM_BINS = 128,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int BIN_W     = $clog2(NUM_BINS),
    localparam int SEARCH_HI = NUM_BINS / 2 - 1,
    localparam int REC_W     = NUM_CH * SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CH_W-1:0]  in_chan,
    input  logic [BIN_W-1:0] in_bin,
    input  logic [AMP_W-1:0] in_amp,
    input  logic [PH_W-1:0]  in_phase,
    output logic             rec_valid,
    output logic [REC_W-1:0] rec_data
);

    peak_t peaks [NUM_CH];
    logic  last_item;

    assign last_item = in_valid && (in_chan == CH_W'(NUM_CH - 1)) &&
                       (in_bin == BIN_W'(NUM_BINS - 1));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic hit_c;
        assign hit_c = in_valid && (in_chan == CH_W'(c));

        peak_tracker #(
            .BIN_W     (BIN_W),
            .SEARCH_HI (SEARCH_HI)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit_c),
            .bin_i  (in_bin),
            .amp_i  (in_amp),
            .ph_i   (in_phase),
            .peak_o (peaks[c])
        );
    end

    record_packer #(
        .NUM_CH (NUM_CH)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_seen (last_item),
        .peaks_i   (peaks),
        .rec_valid (rec_valid),
        .rec_data  (rec_data)
    );

    AST_REC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_item |=> rec_valid); // R1
    AST_NO_STROBE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !rec_valid); // R8

endmodule

// File: tb/peak_select_top_test.sv
`timescale 1ns/1ps
module peak_select_top_test;

    localparam int NCH  = 16;
    localparam int NB   = 128;
    localparam int HI   = NB / 2 - 1;
    localparam int RW   = NCH * 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    in_chan = '0;
    logic [6:0]    in_bin = '0;
    logic [31:0]   in_amp = '0;
    logic [31:0]   in_phase = '0;
    logic          rec_valid;
    logic [RW-1:0] rec_data;

    int checks = 0;
    int fails  = 0;
    logic [RW-1:0] expq[$];
    logic prev_valid = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    peak_select_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_bin(in_bin), .in_amp(in_amp), .in_phase(in_phase),
        .rec_valid(rec_valid), .rec_data(rec_data)
    );

    function automatic logic [31:0] amp_of(int mode, int ch, int bin, int blk);
        logic [31:0] h;
        case (mode)
            0: begin // tone at bin 14, mirror image and DC larger
                if (bin == 0)        return 32'hFFFF_FFF0;
                else if (bin == 14)  return 32'h0100_0000 + 32'(ch);
                else if (bin == 114) return 32'h0200_0000;
                else                 return 32'((bin * 7 + ch) & 255);
            end
            1: return 32'd500;
            2: begin
                h = 32'(bin) * 32'd2654435761 + 32'(ch) * 32'd40503 + 32'(blk) * 32'd977;
                return h ^ (h >> 13);
            end
            3: begin
                if (bin == 0)      return 32'd9;
                else if (bin >= 64) return 32'd77;
                else               return 32'd0;
            end
            default: begin // late tie / window edge
                if (bin == 20 || bin == 40) return 32'd900;
                else if (bin == 63) return (ch % 2 == 0) ? 32'd899 : 32'd901;
                else if (bin == 64) return 32'd5000;
                else return 32'd1;
            end
        endcase
    endfunction

    function automatic logic [31:0] ph_of(int ch, int bin, int blk);
        return (32'(ch) << 24) | (32'(bin) << 8) | 32'(blk & 255);
    endfunction

    function automatic void coords(int k, bit ilv, output int ch, output int bin);
        if (ilv) begin ch = k % NCH; bin = k / NCH; end
        else     begin ch = k / NB;  bin = k % NB;  end
    endfunction

    task automatic run_block(int mode, bit ilv, bit gaps, int blk);
        logic [31:0] eamp [NCH];
        logic [31:0] eph  [NCH];
        bit          has  [NCH];
        logic [RW-1:0] rec;
        int ch, bin;
        logic [31:0] a;
        for (int c = 0; c < NCH; c++) begin eamp[c] = '0; eph[c] = '0; has[c] = 0; end
        for (int k = 0; k < NCH * NB; k++) begin
            coords(k, ilv, ch, bin);
            a = amp_of(mode, ch, bin, blk);
            if (bin == 0) begin
                has[ch] = 0; eamp[ch] = '0; eph[ch] = '0;
            end else if (bin <= HI && (!has[ch] || a > eamp[ch])) begin
                has[ch] = 1; eamp[ch] = a; eph[ch] = ph_of(ch, bin, blk);
            end
        end
        for (int c = 0; c < NCH; c++) rec[c*64 +: 64] = {eph[c], eamp[c]};
        expq.push_back(rec);
        for (int k = 0; k < NCH * NB; k++) begin
            coords(k, ilv, ch, bin);
            @(negedge clk);
            in_valid = 1'b1;
            in_chan  = 4'(ch);
            in_bin   = 7'(bin);
            in_amp   = amp_of(mode, ch, bin, blk);
            in_phase = ph_of(ch, bin, blk);
            if (gaps && k != NCH * NB - 1) begin
                @(negedge clk); // R8: idle cycle showing the final coordinates
                in_valid = 1'b0;
                in_chan  = 4'(NCH - 1);
                in_bin   = 7'(NB - 1);
                in_amp   = 32'hFFFF_FFFF;
                in_phase = 32'hDEAD_BEEF;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_amp   = '0;
        repeat (3) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_valid) begin
                checks++;
                if (rec_valid) begin
                    fails++;
                    $display("FAIL R1 strobe width: rec_valid=%0b expected 0", rec_valid);
                end
            end
            if (rec_valid && !prev_valid) begin
                if (expq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R1 unexpected record: got strobe, expected none");
                end else begin
                    logic [RW-1:0] e;
                    e = expq.pop_front();
                    for (int c = 0; c < NCH; c++) begin
                        checks++; // R2 R3 R4 R5 R6 R7 slot compare
                        if (rec_data[c*64 +: 64] !== e[c*64 +: 64]) begin
                            fails++;
                            $display("FAIL R2/R4 ch%0d slot: actual amp=%h ph=%h expected amp=%h ph=%h",
                                     c, rec_data[c*64 +: 32], rec_data[c*64+32 +: 32],
                                     e[c*64 +: 32], e[c*64+32 +: 32]);
                        end
                    end
                end
            end
            prev_valid = rec_valid;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++; // R9 reset state
        if (rec_valid !== 1'b0 || rec_data !== '0) begin
            fails++;
            $display("FAIL R9 reset: rec_valid=%0b rec_data_nonzero=%0b expected 0/0",
                     rec_valid, |rec_data);
        end
        run_block(0, 0, 0, 1); // R4 tone at bin 14, R3 DC and mirror rejected
        run_block(1, 0, 1, 2); // R5 flat spectrum picks bin 1, R6 after large block, R8 gaps
        run_block(2, 1, 0, 3); // R7 interleaved, unsigned hashed amplitudes
        run_block(3, 0, 0, 4); // R9 all-zero window reports bin 1 phase
        run_block(4, 1, 1, 5); // R5 tie 20/40, R3 bin 64 rejected, bin 63 edge
        run_block(2, 0, 0, 6); // R4 hashed amplitudes, channel-major
        repeat (5) @(negedge clk);
        checks++; // R1 every block produced exactly one record
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R1 missing records: actual pending=%0d expected 0", expq.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule